// File: doc/BRIEF.md
# Power-Management Mailbox Channel Interrupt Generator

This block is a single mailbox channel that sits between a host bus and an embedded controller core. It holds one output byte, which the core writes and the host reads, and one input byte, which the host writes and the core reads. Each byte has a full flag. A status byte is shared by both sides. The core can write the output byte through any of three strobes: a silent one, one that raises an SMI event, and one that raises an SCI event. It can read the input byte through a plain strobe or through one that raises an SCI event. A software trigger input can also raise an SCI event without any read taking place. The block keeps one internal source flag per event kind. Each flag is set by the access that raised the event and is cleared by the opposite event on the matching buffer.

Every event starts a pulse whose length is programmable, with a separate length setting for SMI and for SCI. Each pulse comes from a small generator with two states. In state IDLE the pulse is low. A trigger causes the transition IDLE->ACTIVE and loads the length counter. In state ACTIVE the pulse is high. The counter moves down by one each cycle. When it reaches zero the transition ACTIVE->IDLE takes place. A new trigger during ACTIVE causes the self transition ACTIVE->ACTIVE, which reloads the counter. Each pulse then reaches its active-low pin through a two-level enable with a software bypass value, followed by a polarity inversion bit.

Top module: `pm_mailbox_irq`

## Requirements
- R1: A core write to the output byte through any of the three write strobes stores `core_wdata` in `host_rdata` and sets OBF (status bit 0). The silent strobe does nothing more. The SMI strobe also sets source flag bit 0 (`src_flags[0]`) and triggers an SMI pulse. The SCI strobe also sets `src_flags[1]` and triggers an SCI pulse.
- R2: A host read of the output byte clears OBF, `src_flags[0]` and `src_flags[1]`. If a core write happens in the same cycle, that write wins.
- R3: A core read of the input byte through the SCI read strobe clears IBF (status bit 1), sets `src_flags[2]` and triggers an SCI pulse. A read through the plain strobe clears IBF and does nothing else.
- R4: A host write sets IBF, stores the byte in `core_rdata`, and sets status bit 3 to 1 for a command or 0 for data. It also clears `src_flags[2]`, and this clear takes priority over any setting of that flag in the same cycle.
- R5: A cycle with `sci_trigger` high sets `src_flags[2]` and triggers an SCI pulse. IBF is left unchanged.
- R6: After a trigger, the pulse is high from the next cycle for exactly the programmed width in cycles, and a width of 0 acts as 1. A trigger during a pulse restarts the full width.
- R7: The pin is asserted during the pulse when both the host and core enables are set. When only the core enable is set, the pin is asserted exactly when the software value bit is 1. When the core enable is clear, the pin is not asserted.
- R8: With the invert bit at 0, the pin is low when asserted and high otherwise. With the invert bit at 1, the pin level is the opposite.
- R9: A core status write updates only bits 2 and 4 to 7. Bits 0, 1 and 3 are not affected by it. A single status output serves both the host view and the core view.
- R10: After reset, the status byte, both data bytes and the source flags are 0, no pulse is active, and both pins are high when invert is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| host_wr_data | input | 1 | Host writes data byte to the input buffer |
| host_wr_cmd | input | 1 | Host writes command byte to the input buffer |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host reads the output buffer |
| host_rdata | output | 8 | Output buffer contents |
| core_wr_silent | input | 1 | Core output write, no event |
| core_wr_smi | input | 1 | Core output write raising SMI |
| core_wr_sci | input | 1 | Core output write raising SCI |
| core_wdata | input | 8 | Core write byte |
| core_rd_plain | input | 1 | Core input read, no event |
| core_rd_sci | input | 1 | Core input read raising SCI |
| core_rdata | output | 8 | Input buffer contents |
| core_st_wr | input | 1 | Core status write strobe |
| core_st_wdata | input | 8 | Core status write byte |
| sci_trigger | input | 1 | Software SCI trigger |
| smi_width | input | 4 | SMI pulse width in cycles |
| sci_width | input | 4 | SCI pulse width in cycles |
| smi_host_en | input | 1 | Host-side SMI enable |
| smi_core_en | input | 1 | Core-side SMI enable |
| smi_sw_val | input | 1 | Software SMI value |
| smi_invert | input | 1 | SMI polarity invert |
| sci_host_en | input | 1 | Host-side SCI enable |
| sci_core_en | input | 1 | Core-side SCI enable |
| sci_sw_val | input | 1 | Software SCI value |
| sci_invert | input | 1 | SCI polarity invert |
| status | output | 8 | Shared status byte |
| src_flags | output | 3 | {input-read SCI, output SCI, output SMI} source flags |
| smi_n | output | 1 | SMI pin |
| sci_n | output | 1 | SCI pin |

## Verification
The directed patterns exercise each write and read strobe alone. This separates the silent paths from the paths that raise events, and it shows which source flag each strobe touches. Widths of 0, 1 and the maximum, together with a retrigger in the middle of a pulse, separate the counter bounds from the restart rule. The routing is checked for all combinations of the enables, the bypass value and the inversion bit, so each branch of the three-way choice is seen at the pin. A long random phase mixes simultaneous strobes with configuration changes in the middle of a pulse, so the precedence between a set and a clear in the same cycle is exercised.

// File: rtl/pmirq_pkg.sv
package pmirq_pkg;
    typedef enum logic {
        PG_IDLE   = 1'b0,
        PG_ACTIVE = 1'b1
    } pg_state_t;

    localparam int ST_OBF_BIT = 0;
    localparam int ST_IBF_BIT = 1;
    localparam int ST_CMD_BIT = 3;
    localparam logic [7:0] ST_CORE_MASK = 8'hF4;
endpackage

// File: rtl/pmirq_pulse.sv
module pmirq_pulse
    import pmirq_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [PW-1:0] width,
    output logic          pulse
);
    pg_state_t     state_q, state_d;
    logic [PW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] load_val;

    always_comb begin
        load_val = (width == '0) ? '0 : width - 1'b1;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PG_IDLE: begin
                if (trig) begin
                    state_d = PG_ACTIVE;
                    cnt_d   = load_val;
                end
            end
            PG_ACTIVE: begin
                if (trig) begin
                    cnt_d = load_val;
                end else if (cnt_q == '0) begin
                    state_d = PG_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pulse = (state_q == PG_ACTIVE);
    end

    p_trig_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse);
    p_count_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && cnt_q != '0) |=> pulse);
    p_idle_count_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |-> cnt_q == '0 || $past(trig) == 1'b0);
endmodule

// File: rtl/pmirq_route.sv
module pmirq_route (
    input  logic pulse,
    input  logic host_en,
    input  logic core_en,
    input  logic sw_val,
    input  logic invert,
    output logic pin_n
);
    logic active;

    always_comb begin
        if (!core_en)      active = 1'b0;
        else if (host_en)  active = pulse;
        else               active = sw_val;
        pin_n = ~active ^ invert;
    end
endmodule

// File: rtl/pm_mailbox_irq.sv
module pm_mailbox_irq
    import pmirq_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_data,
    input  logic          host_wr_cmd,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    input  logic          core_wr_silent,
    input  logic          core_wr_smi,
    input  logic          core_wr_sci,
    input  logic [DW-1:0] core_wdata,
    input  logic          core_rd_plain,
    input  logic          core_rd_sci,
    output logic [DW-1:0] core_rdata,
    input  logic          core_st_wr,
    input  logic [7:0]    core_st_wdata,
    input  logic          sci_trigger,
    input  logic [PW-1:0] smi_width,
    input  logic [PW-1:0] sci_width,
    input  logic          smi_host_en,
    input  logic          smi_core_en,
    input  logic          smi_sw_val,
    input  logic          smi_invert,
    input  logic          sci_host_en,
    input  logic          sci_core_en,
    input  logic          sci_sw_val,
    input  logic          sci_invert,
    output logic [7:0]    status,
    output logic [2:0]    src_flags,
    output logic          smi_n,
    output logic          sci_n
);
    logic [DW-1:0] odata_q, idata_q;
    logic          obf_q, ibf_q, cmd_q;
    logic [7:0]    user_q;
    logic          obf_smi_q, obf_sci_q, ibf_sci_q;
    logic          core_wr_any, host_wr_any, core_rd_any;
    logic          smi_trig, sci_trig;
    logic          smi_pulse, sci_pulse;

    always_comb begin
        core_wr_any = core_wr_silent | core_wr_smi | core_wr_sci;
        host_wr_any = host_wr_data | host_wr_cmd;
        core_rd_any = core_rd_plain | core_rd_sci;
        smi_trig    = core_wr_smi;
        sci_trig    = core_wr_sci | core_rd_sci | sci_trigger;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odata_q   <= '0;
            obf_q     <= 1'b0;
            obf_smi_q <= 1'b0;
            obf_sci_q <= 1'b0;
        end else begin
            if (core_wr_any) begin
                odata_q <= core_wdata;
                obf_q   <= 1'b1;
                if (core_wr_smi) obf_smi_q <= 1'b1;
                if (core_wr_sci) obf_sci_q <= 1'b1;
            end else if (host_rd) begin
                obf_q     <= 1'b0;
                obf_smi_q <= 1'b0;
                obf_sci_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idata_q   <= '0;
            ibf_q     <= 1'b0;
            cmd_q     <= 1'b0;
            ibf_sci_q <= 1'b0;
        end else begin
            if (host_wr_any) begin
                idata_q   <= host_wdata;
                ibf_q     <= 1'b1;
                cmd_q     <= host_wr_cmd;
                ibf_sci_q <= 1'b0;
            end else begin
                if (core_rd_any)                 ibf_q     <= 1'b0;
                if (core_rd_sci || sci_trigger)  ibf_sci_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            user_q <= '0;
        end else if (core_st_wr) begin
            user_q <= core_st_wdata & ST_CORE_MASK;
        end
    end

    always_comb begin
        status             = user_q;
        status[ST_OBF_BIT] = obf_q;
        status[ST_IBF_BIT] = ibf_q;
        status[ST_CMD_BIT] = cmd_q;
        host_rdata         = odata_q;
        core_rdata         = idata_q;
        src_flags          = {ibf_sci_q, obf_sci_q, obf_smi_q};
    end

    pmirq_pulse #(.PW(PW)) u_smi_pulse (
        .clk(clk), .rst_n(rst_n), .trig(smi_trig), .width(smi_width), .pulse(smi_pulse)
    );
    pmirq_pulse #(.PW(PW)) u_sci_pulse (
        .clk(clk), .rst_n(rst_n), .trig(sci_trig), .width(sci_width), .pulse(sci_pulse)
    );

    pmirq_route u_smi_route (
        .pulse(smi_pulse), .host_en(smi_host_en), .core_en(smi_core_en),
        .sw_val(smi_sw_val), .invert(smi_invert), .pin_n(smi_n)
    );
    pmirq_route u_sci_route (
        .pulse(sci_pulse), .host_en(sci_host_en), .core_en(sci_core_en),
        .sw_val(sci_sw_val), .invert(sci_invert), .pin_n(sci_n)
    );

    p_wr_sets_obf_r1: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_any |=> status[ST_OBF_BIT]);
    p_src_follow_obf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status[ST_OBF_BIT] |-> (src_flags[1:0] == 2'b00));
    p_rd_clears_ibf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_any && !host_wr_any) |=> !status[ST_IBF_BIT]);
    p_ibf_set_clears_sci_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_any |=> (status[ST_IBF_BIT] && !src_flags[2]));
    p_smi_idle_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_core_en |-> (smi_n == ~smi_invert));
    p_core_bits_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_st_wr && !core_wr_any && !host_rd && !host_wr_any && !core_rd_any)
        |=> $stable({status[ST_CMD_BIT], status[ST_IBF_BIT], status[ST_OBF_BIT]}));
endmodule

// File: tb/test_pm_mailbox_irq.sv
module test_pm_mailbox_irq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_data = 0, host_wr_cmd = 0, host_rd = 0;
    logic [7:0] host_wdata = 0, core_wdata = 0, core_st_wdata = 0;
    logic       core_wr_silent = 0, core_wr_smi = 0, core_wr_sci = 0;
    logic       core_rd_plain = 0, core_rd_sci = 0, core_st_wr = 0, sci_trigger = 0;
    logic [3:0] smi_width = 0, sci_width = 0;
    logic       smi_host_en = 0, smi_core_en = 0, smi_sw_val = 0, smi_invert = 0;
    logic       sci_host_en = 0, sci_core_en = 0, sci_sw_val = 0, sci_invert = 0;
    logic [7:0] host_rdata, core_rdata, status;
    logic [2:0] src_flags;
    logic       smi_n, sci_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_od, m_id, m_user;
    logic       m_obf, m_ibf, m_cmd, m_fsmi, m_fsci, m_fisci;
    logic       m_smi_act, m_sci_act;
    int         m_smi_cnt, m_sci_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_mailbox_irq i_pm_mailbox_irq (
        .clk(clk), .rst_n(rst_n),
        .host_wr_data(host_wr_data), .host_wr_cmd(host_wr_cmd), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .core_wr_silent(core_wr_silent), .core_wr_smi(core_wr_smi), .core_wr_sci(core_wr_sci),
        .core_wdata(core_wdata), .core_rd_plain(core_rd_plain), .core_rd_sci(core_rd_sci),
        .core_rdata(core_rdata), .core_st_wr(core_st_wr), .core_st_wdata(core_st_wdata),
        .sci_trigger(sci_trigger), .smi_width(smi_width), .sci_width(sci_width),
        .smi_host_en(smi_host_en), .smi_core_en(smi_core_en), .smi_sw_val(smi_sw_val),
        .smi_invert(smi_invert), .sci_host_en(sci_host_en), .sci_core_en(sci_core_en),
        .sci_sw_val(sci_sw_val), .sci_invert(sci_invert),
        .status(status), .src_flags(src_flags), .smi_n(smi_n), .sci_n(sci_n)
    );

    function automatic int eff_width(input logic [3:0] w);
        return (w == 0) ? 1 : int'(w);
    endfunction

    function automatic logic exp_pin(input logic pulse, input logic hen, input logic cen,
                                     input logic sw, input logic inv);
        logic a;
        a = cen ? (hen ? pulse : sw) : 1'b0;
        return (~a) ^ inv;
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s = m_user;
        s[0] = m_obf;
        s[1] = m_ibf;
        s[3] = m_cmd;
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_od = 0; m_id = 0; m_user = 0;
        m_obf = 0; m_ibf = 0; m_cmd = 0; m_fsmi = 0; m_fsci = 0; m_fisci = 0;
        m_smi_act = 0; m_sci_act = 0; m_smi_cnt = 0; m_sci_cnt = 0;
    endtask

    task automatic model_step();
        logic cw, hw, st, ct;
        cw = core_wr_silent | core_wr_smi | core_wr_sci;
        hw = host_wr_data | host_wr_cmd;
        // R1 / R2
        if (cw) begin
            m_od = core_wdata; m_obf = 1;
            if (core_wr_smi) m_fsmi = 1;
            if (core_wr_sci) m_fsci = 1;
        end else if (host_rd) begin
            m_obf = 0; m_fsmi = 0; m_fsci = 0;
        end
        // R3 / R4 / R5
        if (hw) begin
            m_id = host_wdata; m_ibf = 1; m_cmd = host_wr_cmd; m_fisci = 0;
        end else begin
            if (core_rd_plain | core_rd_sci) m_ibf = 0;
            if (core_rd_sci | sci_trigger) m_fisci = 1;
        end
        // R9
        if (core_st_wr) m_user = core_st_wdata & 8'hF4;
        // R6
        st = core_wr_smi;
        ct = core_wr_sci | core_rd_sci | sci_trigger;
        if (st) begin m_smi_act = 1; m_smi_cnt = eff_width(smi_width) - 1; end
        else if (m_smi_act) begin
            if (m_smi_cnt == 0) m_smi_act = 0; else m_smi_cnt--;
        end
        if (ct) begin m_sci_act = 1; m_sci_cnt = eff_width(sci_width) - 1; end
        else if (m_sci_act) begin
            if (m_sci_cnt == 0) m_sci_act = 0; else m_sci_cnt--;
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R9 status"}, status, exp_status());
        chk({tag, " R1 host_rdata"}, host_rdata, m_od);
        chk({tag, " R4 core_rdata"}, core_rdata, m_id);
        chk({tag, " R2 src_flags"}, src_flags, {m_fisci, m_fsci, m_fsmi});
        chk({tag, " R7 smi_n"}, smi_n, exp_pin(m_smi_act, smi_host_en, smi_core_en, smi_sw_val, smi_invert));
        chk({tag, " R8 sci_n"}, sci_n, exp_pin(m_sci_act, sci_host_en, sci_core_en, sci_sw_val, sci_invert));
    endtask

    task automatic clear_strobes();
        host_wr_data = 0; host_wr_cmd = 0; host_rd = 0;
        core_wr_silent = 0; core_wr_smi = 0; core_wr_sci = 0;
        core_rd_plain = 0; core_rd_sci = 0; core_st_wr = 0; sci_trigger = 0;
    endtask

    // inputs already set at a negedge: clock them in, update model, compare at next negedge
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        clear_strobes();
        compare_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(negedge clk);
        // R10 reset state
        compare_all("reset R10");
        chk("R10 smi_n high", smi_n, 1'b1);
        chk("R10 sci_n high", sci_n, 1'b1);
        rst_n = 1;
        @(negedge clk);

        // R1 silent write: OBF only, no pulse
        smi_core_en = 1; smi_host_en = 1; sci_core_en = 1; sci_host_en = 1;
        smi_width = 3; sci_width = 2;
        core_wr_silent = 1; core_wdata = 8'hA5;
        cycle("silent");
        chk("R1 silent flags", src_flags, 3'b000);
        chk("R1 silent no smi", smi_n, 1'b1);
        // R2 host read clears OBF
        host_rd = 1;
        cycle("hostrd");
        chk("R2 obf cleared", status[0], 1'b0);

        // R1 SMI write + R6 width 3
        core_wr_smi = 1; core_wdata = 8'h3C;
        cycle("smiwr");
        chk("R1 smi flag", src_flags[0], 1'b1);
        chk("R6 smi pulse c1", smi_n, 1'b0);
        cycle("smi c2");
        cycle("smi c3");
        chk("R6 smi pulse c3", smi_n, 1'b0);
        cycle("smi c4");
        chk("R6 smi pulse end", smi_n, 1'b1);
        host_rd = 1;
        cycle("hostrd2");
        chk("R2 smi flag cleared", src_flags[0], 1'b0);

        // R6 width 0 acts as 1
        sci_width = 0; core_wr_sci = 1;
        cycle("sciw0");
        chk("R6 width0 high", sci_n, 1'b0);
        cycle("sciw0 end");
        chk("R6 width0 one cycle", sci_n, 1'b1);

        // R6 retrigger restarts
        sci_width = 4; sci_trigger = 1;
        cycle("rt1"); cycle("rt2");
        sci_trigger = 1;
        cycle("rt3");
        for (int k = 0; k < 3; k++) cycle("rt tail");
        chk("R6 retrigger still high", sci_n, 1'b0);
        cycle("rt done");
        chk("R6 retrigger ends", sci_n, 1'b1);
        chk("R5 trigger sets ibf sci", src_flags[2], 1'b1);

        // R4 host cmd write, then R3 reads
        host_wr_cmd = 1; host_wdata = 8'h77;
        cycle("hcmd");
        chk("R4 cmd bit", status[3], 1'b1);
        chk("R4 clears ibf sci", src_flags[2], 1'b0);
        core_rd_plain = 1;
        cycle("rdplain");
        chk("R3 plain no flag", src_flags[2], 1'b0);
        host_wr_data = 1; host_wdata = 8'h11;
        cycle("hdata");
        chk("R4 data bit", status[3], 1'b0);
        core_rd_sci = 1;
        cycle("rdsci");
        chk("R3 sci flag", src_flags[2], 1'b1);
        chk("R3 ibf cleared", status[1], 1'b0);

        // R9 status write touches only core bits
        core_st_wr = 1; core_st_wdata = 8'hFF;
        cycle("stwr");
        chk("R9 masked", status & 8'hF4, 8'hF4);

        // R7 / R8 routing sweep
        for (int c = 0; c < 16; c++) begin
            smi_host_en = c[0]; smi_core_en = c[1]; smi_sw_val = c[2]; smi_invert = c[3];
            sci_host_en = c[0]; sci_core_en = c[1]; sci_sw_val = c[2]; sci_invert = c[3];
            core_wr_smi = c[0]; core_rd_sci = c[1];
            cycle("route R7 R8");
        end

        // random phase
        for (int i = 0; i < 4000; i++) begin
            host_wr_data   = ($urandom % 8) == 0;
            host_wr_cmd    = ($urandom % 10) == 0;
            host_wdata     = 8'($urandom);
            host_rd        = ($urandom % 5) == 0;
            core_wr_silent = ($urandom % 9) == 0;
            core_wr_smi    = ($urandom % 12) == 0;
            core_wr_sci    = ($urandom % 12) == 0;
            core_wdata     = 8'($urandom);
            core_rd_plain  = ($urandom % 8) == 0;
            core_rd_sci    = ($urandom % 10) == 0;
            core_st_wr     = ($urandom % 15) == 0;
            core_st_wdata  = 8'($urandom);
            sci_trigger    = ($urandom % 20) == 0;
            if (($urandom % 25) == 0) begin
                smi_width = 4'($urandom); sci_width = 4'($urandom);
                {smi_host_en, smi_core_en, smi_sw_val, smi_invert} = 4'($urandom);
                {sci_host_en, sci_core_en, sci_sw_val, sci_invert} = 4'($urandom);
            end
            cycle("random R1 R2 R3 R4 R5 R6");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule